// File: doc/BRIEF.md
# Pipelined Local Bus Control Unit

This block runs a local memory bus shared by two masters. Each cycle in which the next cycle may carry an address, it decides which requesting master owns the bus. Requests are served in fixed priority order. When nobody asks, the bus rests on the high-priority master. A granted master presents its address and control in the cycle after the grant. The block then steps through one data cycle for a single transfer, or four consecutive data cycles for a block transfer. It forwards each data cycle to a slave port and sends the slave's read data back.

Arbitration and address cycles are pipelined, so they overlap the tail of the transfer ahead. Single transfers can therefore issue every cycle. Every address is checked against a parameterised map of implemented regions. Misaligned block requests are rejected as protocol violations. Either kind of fault is answered with an error in each data cycle of the transfer, and the slave never sees it. The first fault is frozen in a capture register set that software reads and clears. Any later fault only raises an overflow flag.

Top module: `lbus_ctrl`

## Requirements
- R1: At most one grant is driven per cycle. No grant is issued in a cycle whose following cycle cannot be an address cycle: a cycle that is the address cycle of a block transfer, or a cycle with three or more data cycles still to go, including the current one.
- R2: Master 0 has priority over master 1. When both request in an open arbitration cycle, only m_gnt[0] is asserted.
- R3: In an open arbitration cycle with no request, m_gnt equals 2'b01: the bus is parked on master 0, and no transfer starts.
- R4: When a master is granted while it requests, the next cycle is its address cycle. In that cycle the block samples that master's m_addr, m_write and m_blk. The first data cycle, with m_dvld set for that master, is the cycle after that.
- R5: A transfer with m_blk=0 has exactly one data cycle. A transfer with m_blk=1 has four consecutive data cycles, at word addresses base, base+1, base+2 and base+3.
- R6: The next transfer's grant can fall in the last-but-one data cycle of a block, so that its address cycle overlaps the block's last data cycle. Single transfers by one master can be granted in consecutive cycles, which gives one data cycle per clock.
- R7: An address outside every implemented region is an error. The default regions are 0x0000-0x0FFF and 0x8000-0x83FF. For such a transfer, m_err and m_dvld of the owner are set in every data cycle, s_valid stays low and m_rdata is zero.
- R8: A block transfer whose address has bits [1:0] not equal to zero is a protocol violation, and it is answered the same way as in R7.
- R9: In each data cycle of a valid transfer, s_valid is high. s_addr, s_write and s_wdata come from the owning master, where s_wdata is that master's m_wdata in the same cycle. For reads, m_rdata carries s_rdata.
- R10: On the first error, the cycle after the faulting transfer's first data cycle shows the following. ec_valid is 1 and ec_ovf is 0. ec_addr holds the address-cycle address and ec_mid the master index. ec_write and ec_blk hold the transfer's type. ec_data holds the first data cycle's write data, or zero for a read. ec_cause has bit 0 set for an unmapped address and bit 1 set for misalignment.
- R11: While ec_valid is set, a further error sets ec_ovf and leaves all captured fields unchanged.
- R12: An ec_clr pulse clears ec_valid and ec_ovf from the next cycle on.
- R13: During reset and until the internal reset is released, m_gnt, m_dvld, m_err and s_valid are zero and ec_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| m_req | input | NM | Bus request per master |
| m_gnt | output | NM | Bus grant per master |
| m_addr | input | NM x AW | Word address per master, sampled in its address cycle |
| m_write | input | NM | Write (1) or read (0), sampled in the address cycle |
| m_blk | input | NM | Block (1) or single (0) transfer, sampled in the address cycle |
| m_wdata | input | NM x DW | Write data per master, used in its data cycles |
| m_dvld | output | NM | Data cycle for this master |
| m_err | output | NM | Error response in this master's data cycle |
| m_rdata | output | DW | Read data returned to the owning master |
| s_valid | output | 1 | Slave data cycle strobe |
| s_write | output | 1 | Slave write direction |
| s_addr | output | AW | Slave word address |
| s_wdata | output | DW | Slave write data |
| s_rdata | input | DW | Slave read data, same cycle |
| ec_clr | input | 1 | Clears the capture flags |
| ec_valid | output | 1 | Capture holds an error |
| ec_ovf | output | 1 | Another error came while ec_valid was set |
| ec_addr | output | AW | Captured address |
| ec_data | output | DW | Captured write data, or zero for a read |
| ec_mid | output | MIDW | Captured master index |
| ec_write | output | 1 | Captured direction |
| ec_blk | output | 1 | Captured transfer size |
| ec_cause | output | 2 | Bit 0 unmapped, bit 1 misaligned block |

## Verification
The assertions assume that a master holds m_req only while it wants a new transfer. They also assume that a master keeps m_addr, m_write and m_blk steady from its grant through its address cycle, and that ec_clr is a single-cycle pulse. The bench drives every master input on the falling edge. It drops each request in the cycle after its grant, unless it deliberately issues back-to-back transfers. It keeps address and control fixed over the grant and address cycles of every transfer it starts. It sweeps both masters, both directions, both sizes and a set of mapped, unmapped and misaligned addresses. It then forces contention, a block followed by a waiting master, and errors arriving while a capture is still held.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

  // number of data cycles in a block transfer and its beat index width
  localparam int BLK_LEN = 4;
  localparam int BEAT_W  = 2;
  localparam int LEFT_W  = 3;

  typedef struct packed {
    logic misalign;
    logic unmapped;
  } cause_t;

endpackage

// File: rtl/lbc_arb.sv
module lbc_arb #(
  parameter int NM   = 2,
  parameter int MIDW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic            open_i,
  input  logic [NM-1:0]   req_i,
  output logic [NM-1:0]   gnt_o,
  output logic            start_o,
  output logic [MIDW-1:0] own_o
);

  logic found;

  // lowest index wins; master 0 is also the parking owner
  always_comb begin
    found = 1'b0;
    own_o = '0;
    for (int i = 0; i < NM; i++) begin
      if (req_i[i] && !found) begin
        found = 1'b1;
        own_o = MIDW'(i);
      end
    end
  end

  always_comb begin
    gnt_o = '0;
    if (open_i) begin
      if (found) gnt_o[own_o] = 1'b1;
      else       gnt_o[0]     = 1'b1;
    end
  end

  assign start_o = open_i && found;

endmodule

// File: rtl/lbc_decode.sv
module lbc_decode
  import lbc_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NREG = 2,
  parameter logic [NREG-1:0][AW-1:0] REG_BASE = {16'h8000, 16'h0000},
  parameter logic [NREG-1:0][AW-1:0] REG_MASK = {16'hFC00, 16'hF000}
) (
  input  logic [AW-1:0] addr_i,
  input  logic          blk_i,
  output cause_t        cause_o
);

  logic [NREG-1:0] hit;

  for (genvar r = 0; r < NREG; r++) begin : g_region
    assign hit[r] = ((addr_i & REG_MASK[r]) == REG_BASE[r]);
  end

  assign cause_o.unmapped = ~|hit;
  assign cause_o.misalign = blk_i && (addr_i[BEAT_W-1:0] != '0);

endmodule

// File: rtl/lbc_seq.sv
module lbc_seq
  import lbc_pkg::*;
#(
  parameter int NM   = 2,
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int MIDW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [MIDW-1:0]        own_i,
  input  logic [NM-1:0][AW-1:0]  m_addr,
  input  logic [NM-1:0]          m_write,
  input  logic [NM-1:0]          m_blk,
  input  logic [NM-1:0][DW-1:0]  m_wdata,
  input  cause_t                 cause_i,
  input  logic [DW-1:0]          s_rdata,
  output logic [AW-1:0]          aph_addr_o,
  output logic                   aph_blk_o,
  output logic                   open_o,
  output logic [LEFT_W-1:0]      d_left_o,
  output logic [NM-1:0]          m_dvld,
  output logic [NM-1:0]          m_err,
  output logic [DW-1:0]          m_rdata,
  output logic                   s_valid,
  output logic                   s_write,
  output logic [AW-1:0]          s_addr,
  output logic [DW-1:0]          s_wdata,
  output logic                   cap_o,
  output logic [AW-1:0]          cap_addr_o,
  output logic [MIDW-1:0]        cap_mid_o,
  output logic                   cap_write_o,
  output logic                   cap_blk_o,
  output cause_t                 cap_cause_o
);

  // address stage
  logic            aph_v, aph_v_n;
  logic [MIDW-1:0] aph_own, aph_own_n;
  logic            aph_write;

  // data stage
  logic [LEFT_W-1:0] d_left, d_left_n;
  logic [BEAT_W-1:0] d_beat, d_beat_n;
  logic [MIDW-1:0]   d_own, d_own_n;
  logic              d_write, d_write_n;
  logic              d_blk, d_blk_n;
  logic              d_err, d_err_n;
  cause_t            d_cause, d_cause_n;
  logic [AW-1:0]     d_base, d_base_n;
  logic              d_act;

  assign aph_addr_o = m_addr[aph_own];
  assign aph_blk_o  = m_blk[aph_own];
  assign aph_write  = m_write[aph_own];

  // next cycle may be an address cycle only if no data cycle is pending two cycles out
  assign open_o   = (d_left < LEFT_W'(3)) && !(aph_v && aph_blk_o);
  assign d_left_o = d_left;

  always_comb begin
    aph_v_n   = start_i;
    aph_own_n = start_i ? own_i : aph_own;
    d_left_n  = d_left;
    d_beat_n  = d_beat;
    d_own_n   = d_own;
    d_write_n = d_write;
    d_blk_n   = d_blk;
    d_err_n   = d_err;
    d_cause_n = d_cause;
    d_base_n  = d_base;
    if (aph_v) begin
      d_left_n  = aph_blk_o ? LEFT_W'(BLK_LEN) : LEFT_W'(1);
      d_beat_n  = '0;
      d_own_n   = aph_own;
      d_write_n = aph_write;
      d_blk_n   = aph_blk_o;
      d_err_n   = cause_i.unmapped || cause_i.misalign;
      d_cause_n = cause_i;
      d_base_n  = aph_addr_o;
    end else if (d_left != '0) begin
      d_left_n = d_left - LEFT_W'(1);
      d_beat_n = d_beat + BEAT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aph_v   <= 1'b0;
      aph_own <= '0;
      d_left  <= '0;
      d_beat  <= '0;
      d_own   <= '0;
      d_write <= 1'b0;
      d_blk   <= 1'b0;
      d_err   <= 1'b0;
      d_cause <= '0;
      d_base  <= '0;
    end else begin
      aph_v   <= aph_v_n;
      aph_own <= aph_own_n;
      d_left  <= d_left_n;
      d_beat  <= d_beat_n;
      d_own   <= d_own_n;
      d_write <= d_write_n;
      d_blk   <= d_blk_n;
      d_err   <= d_err_n;
      d_cause <= d_cause_n;
      d_base  <= d_base_n;
    end
  end

  assign d_act = (d_left != '0);

  always_comb begin
    m_dvld = '0;
    m_err  = '0;
    if (d_act) begin
      m_dvld[d_own] = 1'b1;
      m_err[d_own]  = d_err;
    end
  end

  assign s_valid = d_act && !d_err;
  assign s_write = d_write;
  assign s_addr  = {d_base[AW-1:BEAT_W], d_base[BEAT_W-1:0] | d_beat};
  assign s_wdata = m_wdata[d_own];
  assign m_rdata = (s_valid && !d_write) ? s_rdata : '0;

  // a faulting transfer is recorded once, in its first data cycle
  assign cap_o       = d_act && d_err && (d_beat == '0);
  assign cap_addr_o  = d_base;
  assign cap_mid_o   = d_own;
  assign cap_write_o = d_write;
  assign cap_blk_o   = d_blk;
  assign cap_cause_o = d_cause;

endmodule

// File: rtl/lbc_errcap.sv
module lbc_errcap
  import lbc_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int MIDW = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            cap_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   data_i,
  input  logic [MIDW-1:0] mid_i,
  input  logic            write_i,
  input  logic            blk_i,
  input  cause_t          cause_i,
  output logic            valid_o,
  output logic            ovf_o,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   data_o,
  output logic [MIDW-1:0] mid_o,
  output logic            write_o,
  output logic            blk_o,
  output cause_t          cause_o
);

  logic valid_n, ovf_n, load;

  // a clear in the same cycle as a new fault makes room for it
  assign load = cap_i && (!valid_o || clr_i);

  always_comb begin
    valid_n = valid_o;
    ovf_n   = ovf_o;
    if (clr_i) begin
      valid_n = 1'b0;
      ovf_n   = 1'b0;
    end
    if (load)               valid_n = 1'b1;
    else if (cap_i)         ovf_n   = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= valid_n;
      ovf_o   <= ovf_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      data_o  <= '0;
      mid_o   <= '0;
      write_o <= 1'b0;
      blk_o   <= 1'b0;
      cause_o <= '0;
    end else if (load) begin
      addr_o  <= addr_i;
      data_o  <= data_i;
      mid_o   <= mid_i;
      write_o <= write_i;
      blk_o   <= blk_i;
      cause_o <= cause_i;
    end
  end

endmodule

// File: rtl/lbus_ctrl.sv
module lbus_ctrl
  import lbc_pkg::*;
#(
  parameter int NM   = 2,
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int NREG = 2,
  parameter logic [NREG-1:0][AW-1:0] REG_BASE = {16'h8000, 16'h0000},
  parameter logic [NREG-1:0][AW-1:0] REG_MASK = {16'hFC00, 16'hF000},
  localparam int MIDW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NM-1:0]         m_req,
  output logic [NM-1:0]         m_gnt,
  input  logic [NM-1:0][AW-1:0] m_addr,
  input  logic [NM-1:0]         m_write,
  input  logic [NM-1:0]         m_blk,
  input  logic [NM-1:0][DW-1:0] m_wdata,
  output logic [NM-1:0]         m_dvld,
  output logic [NM-1:0]         m_err,
  output logic [DW-1:0]         m_rdata,
  output logic                  s_valid,
  output logic                  s_write,
  output logic [AW-1:0]         s_addr,
  output logic [DW-1:0]         s_wdata,
  input  logic [DW-1:0]         s_rdata,
  input  logic                  ec_clr,
  output logic                  ec_valid,
  output logic                  ec_ovf,
  output logic [AW-1:0]         ec_addr,
  output logic [DW-1:0]         ec_data,
  output logic [MIDW-1:0]       ec_mid,
  output logic                  ec_write,
  output logic                  ec_blk,
  output logic [1:0]            ec_cause
);

  // reset asserts at once and leaves on a clock edge
  logic [1:0] rst_sync;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync <= '0;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  logic              seq_open, arb_open, start;
  logic [MIDW-1:0]   own;
  logic [AW-1:0]     aph_addr;
  logic              aph_blk;
  cause_t            dec_cause;
  logic [LEFT_W-1:0] d_left;
  logic              cap;
  logic [AW-1:0]     cap_addr;
  logic [MIDW-1:0]   cap_mid;
  logic              cap_write, cap_blk;
  cause_t            cap_cause, ec_cause_s;

  assign arb_open = seq_open && rst_n;

  lbc_arb #(.NM(NM), .MIDW(MIDW)) u_arb (
    .open_i  (arb_open),
    .req_i   (m_req),
    .gnt_o   (m_gnt),
    .start_o (start),
    .own_o   (own)
  );

  lbc_decode #(.AW(AW), .NREG(NREG), .REG_BASE(REG_BASE), .REG_MASK(REG_MASK)) u_dec (
    .addr_i  (aph_addr),
    .blk_i   (aph_blk),
    .cause_o (dec_cause)
  );

  lbc_seq #(.NM(NM), .AW(AW), .DW(DW), .MIDW(MIDW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .start_i     (start),
    .own_i       (own),
    .m_addr      (m_addr),
    .m_write     (m_write),
    .m_blk       (m_blk),
    .m_wdata     (m_wdata),
    .cause_i     (dec_cause),
    .s_rdata     (s_rdata),
    .aph_addr_o  (aph_addr),
    .aph_blk_o   (aph_blk),
    .open_o      (seq_open),
    .d_left_o    (d_left),
    .m_dvld      (m_dvld),
    .m_err       (m_err),
    .m_rdata     (m_rdata),
    .s_valid     (s_valid),
    .s_write     (s_write),
    .s_addr      (s_addr),
    .s_wdata     (s_wdata),
    .cap_o       (cap),
    .cap_addr_o  (cap_addr),
    .cap_mid_o   (cap_mid),
    .cap_write_o (cap_write),
    .cap_blk_o   (cap_blk),
    .cap_cause_o (cap_cause)
  );

  lbc_errcap #(.AW(AW), .DW(DW), .MIDW(MIDW)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .clr_i   (ec_clr),
    .cap_i   (cap),
    .addr_i  (cap_addr),
    .data_i  (cap_write ? s_wdata : '0),
    .mid_i   (cap_mid),
    .write_i (cap_write),
    .blk_i   (cap_blk),
    .cause_i (cap_cause),
    .valid_o (ec_valid),
    .ovf_o   (ec_ovf),
    .addr_o  (ec_addr),
    .data_o  (ec_data),
    .mid_o   (ec_mid),
    .write_o (ec_write),
    .blk_o   (ec_blk),
    .cause_o (ec_cause_s)
  );

  assign ec_cause = ec_cause_s;

endmodule

// File: rtl/lbc_chk.sv
module lbc_chk #(
  parameter int NM = 2,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NM-1:0] m_req,
  input logic [NM-1:0] m_gnt,
  input logic [NM-1:0] m_dvld,
  input logic [NM-1:0] m_err,
  input logic          s_valid,
  input logic          arb_open,
  input logic [2:0]    d_left,
  input logic          ec_valid,
  input logic          ec_ovf,
  input logic          ec_clr,
  input logic [AW-1:0] ec_addr
);

  // R1
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_gnt));

  // R2
  gnt_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req[0] && (|m_gnt)) |-> m_gnt[0]);

  // R3
  park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_open && !(|m_req)) |-> (m_gnt == NM'(1)));

  // R6
  blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_left >= 3'd3) |-> (m_gnt == '0));

  // R4
  dvld_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(m_gnt & m_req)) |=> ##1 (m_dvld == $past(m_gnt & m_req, 2)));

  // R7
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid |-> (m_err == '0));

  // R11
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ec_ovf) |-> $past(ec_valid));

  // R11
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ec_valid && $past(ec_valid) && !$past(ec_clr)) |-> $stable(ec_addr));

endmodule

bind lbus_ctrl lbc_chk #(.NM(NM), .AW(AW)) u_chk (
  .clk      (clk_i),
  .rst_n    (rst_n),
  .m_req    (m_req),
  .m_gnt    (m_gnt),
  .m_dvld   (m_dvld),
  .m_err    (m_err),
  .s_valid  (s_valid),
  .arb_open (arb_open),
  .d_left   (d_left),
  .ec_valid (ec_valid),
  .ec_ovf   (ec_ovf),
  .ec_clr   (ec_clr),
  .ec_addr  (ec_addr)
);

// File: tb/sim_lbus_ctrl.sv
`timescale 1ns/1ps
module sim_lbus_ctrl;

  localparam int NM = 2;
  localparam int AW = 16;
  localparam int DW = 32;

  logic                  clk = 1'b0;
  logic                  rst_ni;
  logic [NM-1:0]         m_req;
  logic [NM-1:0]         m_gnt;
  logic [NM-1:0][AW-1:0] m_addr;
  logic [NM-1:0]         m_write;
  logic [NM-1:0]         m_blk;
  logic [NM-1:0][DW-1:0] m_wdata;
  logic [NM-1:0]         m_dvld;
  logic [NM-1:0]         m_err;
  logic [DW-1:0]         m_rdata;
  logic                  s_valid;
  logic                  s_write;
  logic [AW-1:0]         s_addr;
  logic [DW-1:0]         s_wdata;
  logic [DW-1:0]         s_rdata;
  logic                  ec_clr;
  logic                  ec_valid;
  logic                  ec_ovf;
  logic [AW-1:0]         ec_addr;
  logic [DW-1:0]         ec_data;
  logic                  ec_mid;
  logic                  ec_write;
  logic                  ec_blk;
  logic [1:0]            ec_cause;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  // behavioural slave: read data is a fixed function of the address
  assign s_rdata = {~s_addr, s_addr};

  lbus_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .m_req(m_req), .m_gnt(m_gnt), .m_addr(m_addr),
    .m_write(m_write), .m_blk(m_blk), .m_wdata(m_wdata), .m_dvld(m_dvld), .m_err(m_err),
    .m_rdata(m_rdata), .s_valid(s_valid), .s_write(s_write), .s_addr(s_addr),
    .s_wdata(s_wdata), .s_rdata(s_rdata), .ec_clr(ec_clr), .ec_valid(ec_valid),
    .ec_ovf(ec_ovf), .ec_addr(ec_addr), .ec_data(ec_data), .ec_mid(ec_mid),
    .ec_write(ec_write), .ec_blk(ec_blk), .ec_cause(ec_cause)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic bit mapped(input logic [15:0] a);
    return (a < 16'h1000) || (a >= 16'h8000 && a < 16'h8400);
  endfunction

  function automatic logic [31:0] pat(input int m, input int b);
    return 32'hC0DE_0000 | (m << 8) | b;
  endfunction

  task automatic nxt();
    @(negedge clk);
  endtask

  // one transfer from an idle bus, checked cycle by cycle
  task automatic xfer_solo(input int m, input logic [15:0] a, input bit wr, input bit blk, input bit clr);
    int  len = blk ? 4 : 1;
    bit  unm = !mapped(a);
    bit  mis = blk && (a[1:0] != 2'b00);
    bit  er  = unm || mis;
    string erq = mis ? "R8" : (unm ? "R7" : "R9");
    logic [15:0] ea;
    nxt();
    m_req[m] = 1'b1; m_addr[m] = a; m_write[m] = wr; m_blk[m] = blk; ec_clr = clr;
    #1 chk("R2", "grant to requester", m_gnt, 32'(1 << m));
    nxt();
    m_req[m] = 1'b0; ec_clr = 1'b0;
    #1;
    if (blk) chk("R1", "no grant in block address cycle", m_gnt, 0);
    else     chk("R3", "park in single address cycle", m_gnt, 1);
    chk("R4", "no data in address cycle", m_dvld, 0);
    for (int b = 0; b < len; b++) begin
      nxt();
      m_wdata[m] = pat(m, b);
      #1;
      ea = a + 16'(b);
      chk("R5", "data cycle owner", m_dvld, 32'(1 << m));
      chk(erq, "error response", m_err, er ? 32'(1 << m) : 0);
      chk(erq, "slave strobe", s_valid, !er);
      if (!er) begin
        chk("R9", "slave address", s_addr, ea);
        chk("R9", "slave direction", s_write, wr);
        if (wr) chk("R9", "slave write data", s_wdata, pat(m, b));
        else    chk("R9", "read data", m_rdata, {~ea, ea});
      end else begin
        chk(erq, "read data zero on error", m_rdata, 0);
      end
    end
    nxt();
    #1 chk("R5", "transfer ended", m_dvld, 0);
    if (clr) begin
      chk("R10", "capture valid", ec_valid, er);
      if (er) begin
        chk("R10", "capture address", ec_addr, a);
        chk("R10", "capture master", ec_mid, m);
        chk("R10", "capture direction", ec_write, wr);
        chk("R10", "capture size", ec_blk, blk);
        chk("R10", "capture cause", ec_cause, {mis, unm});
        chk("R10", "capture data", ec_data, wr ? pat(m, 0) : 0);
        chk("R11", "no overflow on first error", ec_ovf, 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [15:0] addrs [8];
    addrs[0] = 16'h0000; addrs[1] = 16'h0FFC; addrs[2] = 16'h0FFE; addrs[3] = 16'h1000;
    addrs[4] = 16'h8000; addrs[5] = 16'h83FC; addrs[6] = 16'h8401; addrs[7] = 16'hFFF0;
    rst_ni = 1'b0; m_req = '0; m_addr = '0; m_write = '0; m_blk = '0; m_wdata = '0; ec_clr = 1'b0;
    repeat (3) nxt();
    #1;
    chk("R13", "grant in reset", m_gnt, 0);
    chk("R13", "data in reset", m_dvld, 0);
    chk("R13", "slave idle in reset", s_valid, 0);
    chk("R13", "capture clear in reset", ec_valid, 0);
    rst_ni = 1'b1;
    nxt();
    #1 chk("R13", "no grant before internal release", m_gnt, 0);
    repeat (3) nxt();
    #1 chk("R3", "idle bus parked on master 0", m_gnt, 1);

    // sweep masters, directions, sizes and addresses
    for (int m = 0; m < NM; m++)
      for (int w = 0; w < 2; w++)
        for (int k = 0; k < 2; k++)
          for (int i = 0; i < 8; i++)
            xfer_solo(m, addrs[i], w[0], k[0], 1'b1);

    // contention, second grant overlaps first transfer
    nxt();
    m_req = 2'b11; m_addr[0] = 16'h0010; m_write[0] = 1'b0; m_blk[0] = 1'b0;
    m_addr[1] = 16'h8004; m_write[1] = 1'b1; m_blk[1] = 1'b0;
    #1 chk("R2", "both request, master 0 wins", m_gnt, 1);
    nxt(); m_req = 2'b10;
    #1 chk("R6", "loser granted in next cycle", m_gnt, 2);
    nxt(); m_req = 2'b00;
    #1 chk("R4", "master 0 data", m_dvld, 1);
    chk("R9", "master 0 address", s_addr, 16'h0010);
    nxt(); m_wdata[1] = 32'h1234_5678;
    #1 chk("R6", "master 1 data right after", m_dvld, 2);
    chk("R9", "master 1 address", s_addr, 16'h8004);
    chk("R9", "master 1 write data", s_wdata, 32'h1234_5678);
    nxt();
    #1 chk("R5", "pair done", m_dvld, 0);

    // block on master 1, master 0 waits until the last-but-one beat
    nxt();
    m_req = 2'b10; m_addr[1] = 16'h8010; m_write[1] = 1'b0; m_blk[1] = 1'b1;
    #1 chk("R2", "block granted", m_gnt, 2);
    nxt();
    m_req = 2'b01; m_addr[0] = 16'h0020; m_write[0] = 1'b0; m_blk[0] = 1'b0;
    #1 chk("R6", "held in block address cycle", m_gnt, 0);
    for (int b = 0; b < 4; b++) begin
      nxt();
      if (b == 3) m_req = 2'b00;
      #1;
      chk("R5", "block beat owner", m_dvld, 2);
      chk("R5", "block beat address", s_addr, 16'h8010 + 16'(b));
      if (b < 2)       chk("R6", "no preemption inside block", m_gnt, 0);
      else if (b == 2) chk("R6", "waiting master granted", m_gnt, 1);
    end
    nxt();
    #1 chk("R6", "waiting master data after block", m_dvld, 1);
    chk("R9", "waiting master address", s_addr, 16'h0020);
    nxt();
    #1 chk("R5", "block sequence done", m_dvld, 0);

    // back-to-back singles from master 0
    nxt(); m_req = 2'b01; m_blk[0] = 1'b0; m_write[0] = 1'b0;
    #1 chk("R6", "first of three grants", m_gnt, 1);
    nxt(); m_addr[0] = 16'h0100;
    #1 chk("R6", "second grant", m_gnt, 1);
    nxt(); m_addr[0] = 16'h0102;
    #1 chk("R6", "third grant", m_gnt, 1);
    chk("R6", "first single data", s_addr, 16'h0100);
    nxt(); m_addr[0] = 16'h0104; m_req = 2'b00;
    #1 chk("R6", "second single data", s_addr, 16'h0102);
    chk("R6", "second single strobe", s_valid, 1);
    nxt();
    #1 chk("R6", "third single data", s_addr, 16'h0104);
    chk("R6", "third single strobe", s_valid, 1);
    nxt();
    #1 chk("R5", "singles done", m_dvld, 0);

    // overflow keeps the first capture, clear empties it
    xfer_solo(1, 16'h2000, 1'b0, 1'b0, 1'b1);
    xfer_solo(0, 16'h9000, 1'b1, 1'b0, 1'b0);
    #1;
    chk("R11", "overflow set", ec_ovf, 1);
    chk("R11", "first address kept", ec_addr, 16'h2000);
    chk("R11", "first master kept", ec_mid, 1);
    chk("R11", "first direction kept", ec_write, 0);
    nxt(); ec_clr = 1'b1;
    nxt(); ec_clr = 1'b0;
    #1;
    chk("R12", "valid cleared", ec_valid, 0);
    chk("R12", "overflow cleared", ec_ovf, 0);

    repeat (2) nxt();
    summary();
  end

endmodule